// File: doc/BRIEF.md
# Quad Special-Wakeup Register Unit

This block is a register target that sits in front of a group of four processor cores. Power-management firmware uses it to hold special-wakeup requests for individual cores. Each core's request is a level output that stays asserted until firmware clears it. The block also keeps a single shared completion flag, and firmware can poll that flag through a status register.

Accesses arrive on a simple 64-bit request port. A request carries a 32-bit register index, a read/write flag, a byte count and write data. The data is already arranged as a big-endian 64-bit word, so data bit 0 in MSB-0 numbering is `req_wdata[63]`. The index also uses MSB-0 numbering. Four of its bits pick which cores a write targets, and those bits are removed from the index before it is decoded, so the same register answers at sixteen index values.

Each request gets exactly one response on the following cycle. That response carries the read data and a flag that marks the access as unimplemented.

Top module: `qsw_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `wake_req` is 0, `wake_done` is 0 and `rsp_valid` is 0.
- R2: An 8-byte write whose decoded index is 0x83c sets `wake_done` to `req_wdata[63]`. The other data bits have no effect, and the response returns `rsp_rdata` = 0 with `rsp_unimpl` = 0.
- R3: In that write, core i is selected when index bit 16+i (MSB-0) is 1, which is `req_index[15-i]`. That gives 0x8000 for core 0, 0x4000 for core 1, 0x2000 for core 2 and 0x1000 for core 3. Every selected core's `wake_req[i]` is set to `req_wdata[63]`.
- R4: In that write, cores whose select bit is 0 keep their previous `wake_req` value.
- R5: A write to 0x83c that selects no cores still updates `wake_done`.
- R6: An 8-byte read whose decoded index is 0x82c returns 0x4800_0000_0000_0000 when the done flag is set, and 0 when it is clear. These are MSB-0 bits 1 and 4. The response has `rsp_unimpl` = 0.
- R7: A read of any other index returns all ones with `rsp_unimpl` = 1. This includes a read of 0x83c.
- R8: A write to any other index, including 0x82c, leaves `wake_req` and `wake_done` unchanged. It returns `rsp_rdata` = 0 with `rsp_unimpl` = 1.
- R9: An access whose byte count is not 8 is treated as unimplemented, whatever its index. A read returns all ones, a write is ignored, and `rsp_unimpl` = 1.
- R10: Index bits 16 to 19 (`req_index[15:12]`) never affect decode. A status read still hits 0x82c when those bits are set.
- R11: `rsp_valid` is 1 on the cycle after each accepted request, including on back-to-back requests, and 0 after every cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 32 | Register index, MSB-0; bits 16..19 select cores |
| req_wdata | input | 64 | Big-endian write data |
| req_bytes | input | 4 | Access size in bytes; only 8 is legal |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Read data |
| rsp_unimpl | output | 1 | Access targeted no implemented register or had a bad size |
| wake_req | output | 4 | Per-core wakeup request levels |
| wake_done | output | 1 | Shared wakeup completion flag |

## Verification
A request sampled at clock edge N has its response on `rsp_*` just after edge N, and a register write is visible on `wake_req` and `wake_done` just after the same edge. A status read reports the done flag as it stood before edge N. The bench stamps every expected item with the cycle in which it falls due, and the monitor reads outputs on the falling edge. The monitor rejects a response that arrives in any cycle other than its stamped one, and it also rejects a missing response or a stray one. The modelled wake and done values are compared in the same falling-edge sample as the response they accompany.

// File: rtl/qsw_pkg.sv
package qsw_pkg;

    localparam int QSW_IDX_W        = 32;
    localparam int QSW_DATA_W       = 64;
    localparam int QSW_CORES        = 4;
    localparam int QSW_SEL_FIRST    = 16;   // MSB-0 position of core 0 select
    localparam int QSW_BYTES_W      = 4;
    localparam int QSW_ACCESS_BYTES = 8;
    localparam logic [31:0] QSW_WAKE_OFF = 32'h0000_083c;
    localparam logic [31:0] QSW_STAT_OFF = 32'h0000_082c;

    typedef enum logic [1:0] {
        KIND_IDLE    = 2'd0,
        KIND_WAKE_WR = 2'd1,
        KIND_STAT_RD = 2'd2,
        KIND_UNIMPL  = 2'd3
    } qsw_kind_e;

    typedef struct packed {
        qsw_kind_e kind;
        logic      is_write;
        logic      set_val;
    } qsw_cmd_t;

    // Convert an MSB-0 bit number into the LSB-0 vector index.
    function automatic int msb0_bit(input int width, input int pos);
        return width - 1 - pos;
    endfunction

endpackage

// File: rtl/qsw_decode.sv
module qsw_decode
    import qsw_pkg::*;
#(
    parameter int IDX_W        = QSW_IDX_W,
    parameter int NUM_CORES    = QSW_CORES,
    parameter int SEL_FIRST    = QSW_SEL_FIRST,
    parameter int BYTES_W      = QSW_BYTES_W,
    parameter int ACCESS_BYTES = QSW_ACCESS_BYTES,
    parameter logic [IDX_W-1:0] WAKE_OFF = IDX_W'(QSW_WAKE_OFF),
    parameter logic [IDX_W-1:0] STAT_OFF = IDX_W'(QSW_STAT_OFF)
) (
    input  logic                 valid,
    input  logic                 write,
    input  logic [IDX_W-1:0]     index,
    input  logic                 set_bit,
    input  logic [BYTES_W-1:0]   nbytes,
    output qsw_cmd_t             cmd,
    output logic [NUM_CORES-1:0] sel
);

    logic [IDX_W-1:0] sel_mask;
    logic [IDX_W-1:0] reg_index;
    logic             size_ok;

    for (genvar i = 0; i < IDX_W; i++) begin : g_mask
        localparam int POS_MSB0 = msb0_bit(IDX_W, i);
        localparam bit IN_SEL   = (POS_MSB0 >= SEL_FIRST) &&
                                  (POS_MSB0 <  SEL_FIRST + NUM_CORES);
        assign sel_mask[i] = IN_SEL;
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_sel
        assign sel[c] = index[msb0_bit(IDX_W, SEL_FIRST + c)];
    end

    assign reg_index = index & ~sel_mask;
    assign size_ok   = (nbytes == BYTES_W'(ACCESS_BYTES));

    always_comb begin
        cmd.is_write = write;
        cmd.set_val  = set_bit;
        if (!valid)
            cmd.kind = KIND_IDLE;
        else if (size_ok && write && reg_index == WAKE_OFF)
            cmd.kind = KIND_WAKE_WR;
        else if (size_ok && !write && reg_index == STAT_OFF)
            cmd.kind = KIND_STAT_RD;
        else
            cmd.kind = KIND_UNIMPL;
    end

endmodule

// File: rtl/qsw_state.sv
module qsw_state
    import qsw_pkg::*;
#(
    parameter int NUM_CORES = QSW_CORES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_hit,
    input  logic                 set_val,
    input  logic [NUM_CORES-1:0] sel,
    output logic [NUM_CORES-1:0] wake,
    output logic                 done
);

    always_ff @(posedge clk) begin
        if (rst)
            done <= 1'b0;
        else if (wr_hit)
            done <= set_val;
    end

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
        always_ff @(posedge clk) begin
            if (rst)
                wake[i] <= 1'b0;
            else if (wr_hit && sel[i])
                wake[i] <= set_val;
        end

        assert_sel_write_R3: assert property (@(posedge clk) disable iff (rst)
            (wr_hit && sel[i]) |=> (wake[i] == $past(set_val)));

        assert_unsel_keep_R4: assert property (@(posedge clk) disable iff (rst)
            (wr_hit && !sel[i]) |=> $stable(wake[i]));
    end

    assert_done_follow_R2: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (done == $past(set_val)));

    assert_ignore_other_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> ($stable(wake) && $stable(done)));

endmodule

// File: rtl/qsw_resp.sv
module qsw_resp
    import qsw_pkg::*;
#(
    parameter int DATA_W = QSW_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  qsw_cmd_t          cmd,
    input  logic              done,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_unimpl
);

    localparam logic [DATA_W-1:0] ONE_W     = DATA_W'(1);
    localparam logic [DATA_W-1:0] STAT_WORD =
        (ONE_W << msb0_bit(DATA_W, 1)) | (ONE_W << msb0_bit(DATA_W, 4));

    logic [DATA_W-1:0] rdata_next;

    always_comb begin
        unique case (cmd.kind)
            KIND_STAT_RD: rdata_next = done ? STAT_WORD : '0;
            KIND_UNIMPL:  rdata_next = cmd.is_write ? '0 : '1;
            default:      rdata_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
            rsp_unimpl <= 1'b0;
        end else begin
            rsp_valid  <= (cmd.kind != KIND_IDLE);
            rsp_rdata  <= rdata_next;
            rsp_unimpl <= (cmd.kind == KIND_UNIMPL);
        end
    end

    assert_rsp_next_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind != KIND_IDLE) |=> rsp_valid);

    assert_rsp_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind == KIND_IDLE) |=> !rsp_valid);

    assert_unimpl_ones_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind == KIND_UNIMPL && !cmd.is_write) |=>
            (rsp_unimpl && (rsp_rdata == '1)));

    assert_stat_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind == KIND_STAT_RD && !done) |=> (rsp_rdata == '0 && !rsp_unimpl));

endmodule

// File: rtl/qsw_unit.sv
module qsw_unit
    import qsw_pkg::*;
#(
    parameter int IDX_W     = QSW_IDX_W,
    parameter int DATA_W    = QSW_DATA_W,
    parameter int NUM_CORES = QSW_CORES,
    parameter int BYTES_W   = QSW_BYTES_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [IDX_W-1:0]     req_index,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [BYTES_W-1:0]   req_bytes,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic                 rsp_unimpl,
    output logic [NUM_CORES-1:0] wake_req,
    output logic                 wake_done
);

    qsw_cmd_t             cmd;
    logic [NUM_CORES-1:0] sel;
    logic                 wr_hit;
    logic                 unused_wdata_low;

    // Only the MSB-0 bit 0 of the data word carries meaning.
    assign unused_wdata_low = ^req_wdata[DATA_W-2:0];

    qsw_decode #(
        .IDX_W     (IDX_W),
        .NUM_CORES (NUM_CORES),
        .BYTES_W   (BYTES_W)
    ) u_decode (
        .valid   (req_valid),
        .write   (req_write),
        .index   (req_index),
        .set_bit (req_wdata[DATA_W-1]),
        .nbytes  (req_bytes),
        .cmd     (cmd),
        .sel     (sel)
    );

    assign wr_hit = (cmd.kind == KIND_WAKE_WR);

    qsw_state #(
        .NUM_CORES (NUM_CORES)
    ) u_state (
        .clk     (clk),
        .rst     (rst),
        .wr_hit  (wr_hit),
        .set_val (cmd.set_val),
        .sel     (sel),
        .wake    (wake_req),
        .done    (wake_done)
    );

    qsw_resp #(
        .DATA_W (DATA_W)
    ) u_resp (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .done       (wake_done),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .rsp_unimpl (rsp_unimpl)
    );

endmodule

// File: tb/test_qsw_unit.sv
`timescale 1ns/1ps
module test_qsw_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_write;
    logic [31:0] req_index;
    logic [63:0] req_wdata;
    logic [3:0]  req_bytes;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        rsp_unimpl;
    logic [3:0]  wake_req;
    logic        wake_done;

    always #4 clk = ~clk;   // 125 MHz

    qsw_unit i_qsw_unit (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_index(req_index),
        .req_wdata(req_wdata), .req_bytes(req_bytes),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_unimpl(rsp_unimpl),
        .wake_req(wake_req), .wake_done(wake_done)
    );

    typedef struct packed {
        logic [63:0] rdata;
        logic        unimpl;
        logic [3:0]  wake;
        logic        done;
        logic [31:0] due;
    } exp_t;

    localparam logic [63:0] STAT_SET = 64'h4800_0000_0000_0000;

    exp_t        exp_q[$];
    string       tag_q[$];
    int          checks = 0;
    int          fails  = 0;
    logic [31:0] cyc    = '0;
    logic [3:0]  wake_m;
    logic        done_m;
    exp_t        mon_e;
    string       mon_t;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Driver: present one request and push its predicted result.
    task automatic acc(input logic wr, input logic [31:0] idx, input logic [63:0] d,
                       input logic [3:0] nb, input string tag);
        exp_t        e;
        logic [31:0] m;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_index = idx;
        req_wdata = d;    req_bytes = nb;
        m = idx & ~32'h0000_F000;
        e.unimpl = 1'b1;
        e.rdata  = wr ? 64'd0 : '1;
        if (nb == 4'd8 && wr && m == 32'h83c) begin
            e.unimpl = 1'b0; e.rdata = 64'd0;
            done_m = d[63];
            for (int i = 0; i < 4; i++) if (idx[15-i]) wake_m[i] = d[63];
        end else if (nb == 4'd8 && !wr && m == 32'h82c) begin
            e.unimpl = 1'b0;
            e.rdata  = done_m ? STAT_SET : 64'd0;
        end
        e.wake = wake_m; e.done = done_m; e.due = cyc + 1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic check_reset(input string tag);
        @(negedge clk);
        checks++;
        if (wake_req !== 4'd0 || wake_done !== 1'b0 || rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL %s: wake=%h done=%b valid=%b expected wake=0 done=0 valid=0",
                     tag, wake_req, wake_done, rsp_valid);
        end
    endtask

    // Monitor: compare each response in the cycle it falls due.
    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R11 stray response: valid=1 expected valid=0");
                end else begin
                    mon_e = exp_q.pop_front();
                    mon_t = tag_q.pop_front();
                    if (mon_e.due != cyc || rsp_rdata !== mon_e.rdata ||
                        rsp_unimpl !== mon_e.unimpl || wake_req !== mon_e.wake ||
                        wake_done !== mon_e.done) begin
                        fails++;
                        $display("FAIL %s: cyc=%0d rdata=%h unimpl=%b wake=%h done=%b expected cyc=%0d rdata=%h unimpl=%b wake=%h done=%b",
                                 mon_t, cyc, rsp_rdata, rsp_unimpl, wake_req, wake_done,
                                 mon_e.due, mon_e.rdata, mon_e.unimpl, mon_e.wake, mon_e.done);
                    end
                end
            end else if (exp_q.size() != 0 && exp_q[0].due <= cyc) begin
                checks++;
                fails++;
                mon_e = exp_q.pop_front();
                mon_t = tag_q.pop_front();
                $display("FAIL R11 missing response for %s: valid=0 expected valid=1", mon_t);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R11 watchdog: cycles=%0d expected fewer than 20000", cyc);
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
        req_index = '0; req_wdata = '0; req_bytes = 4'd8;
        wake_m = 4'd0; done_m = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_reset("R1 after power-on reset");

        acc(1'b0, 32'h82c, 64'd0, 4'd8, "R6 status read, done clear");
        acc(1'b1, 32'h83c | 32'h8000, 64'h8000_0000_0000_0000, 4'd8, "R2 R3 set core0");
        acc(1'b1, 32'h83c | 32'h3000, 64'h8000_0000_0000_0000, 4'd8, "R3 set cores2,3");
        acc(1'b1, 32'h83c | 32'h4000, 64'h7FFF_FFFF_FFFF_FFFF, 4'd8, "R2 R4 clear core1 only");
        acc(1'b1, 32'h83c, 64'h8000_0000_0000_0000, 4'd8, "R5 no cores selected");
        acc(1'b0, 32'h82c, 64'd0, 4'd8, "R6 status read, done set");
        acc(1'b0, 32'h82c | 32'hF000, 64'd0, 4'd8, "R10 select bits on status read");
        acc(1'b0, 32'h900, 64'd0, 4'd8, "R7 unknown read");
        acc(1'b0, 32'h83c, 64'd0, 4'd8, "R7 read of write register");
        acc(1'b1, 32'h82c, 64'd0, 4'd8, "R8 write to status register");
        acc(1'b1, 32'h123 | 32'hF000, 64'd0, 4'd8, "R8 write to unknown");
        acc(1'b1, 32'h83c | 32'hF000, 64'd0, 4'd4, "R9 short write ignored");
        acc(1'b0, 32'h82c, 64'd0, 4'd2, "R9 short read");
        idle(2);
        checks++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R11 idle: valid=%b expected 0", rsp_valid);
        end

        acc(1'b1, 32'h83c | 32'h5000, 64'h0, 4'd8, "R3 R2 clear cores1,3");
        acc(1'b1, 32'h83c | 32'hF000, 64'h8000_0000_0000_0001, 4'd8, "R3 set all cores");
        acc(1'b1, 32'h83c | 32'h2000, 64'h0, 4'd8, "R4 clear core2 keep others");
        acc(1'b0, 32'h82c | 32'h8000, 64'd0, 4'd8, "R10 status after clears");
        idle(3);

        @(negedge clk);
        rst = 1'b1;
        wake_m = 4'd0; done_m = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check_reset("R1 reset after activity");
        acc(1'b0, 32'h82c, 64'd0, 4'd8, "R1 R6 status clear after reset");
        idle(3);

        summary();
        $finish;
    end

endmodule